// File: doc/BRIEF.md
# Packet Assembler with Acknowledged Resend

This block sits between a byte-oriented serial link and a packet radio. Bytes that arrive from a UART receiver are written into a circular byte store. They are grouped into packets. A packet closes when the line has been quiet for a programmable number of character times, or at once when it reaches its size cap. Closed packets are streamed out one at a time as a byte burst with start and end markers. After the radio reports that the burst has gone out, the block opens an acknowledgement window. If the window expires with no acknowledgement, the same bytes are streamed again. After the final unanswered attempt, a failure pulse is raised and the packet is discarded.

In the other direction, bytes that the radio has received are queued and handed to a UART transmitter one at a time. Hand-off happens only while the host's request-to-send input is low and the transmitter reports it is ready. Clear-to-send is lowered towards the sender whenever the byte store has less free room than one full packet.

Top module: `pkt_retx_buffer`

## Requirements
- R1: A group of accepted bytes is held back until `idle_chars` character times pass with no new byte (one character time = 10 `baud_tick` pulses). The whole group then goes out as a single packet. A byte arriving before that point restarts the quiet-time count.
- R2: With `idle_chars` equal to 0, every accepted byte closes its packet on the next cycle, so each byte forms a packet of its own, even when bytes arrive on back-to-back cycles.
- R3: A packet closes as soon as it holds 100 bytes. The next accepted byte opens a new packet.
- R4: A packet is streamed on consecutive cycles in arrival order. `pkt_sop` is high with the first byte only, and `pkt_eop` is high with the last byte only.
- R5: An `ack_in` pulse within ACK_WAIT cycles after `tx_done` retires the packet, and that packet is not streamed again.
- R6: If no acknowledgement arrives within the window, the identical packet is streamed again. This repeats for at most 3 resends, giving 4 transmissions in total.
- R7: When the fourth transmission's window expires unanswered, `ack_fail` is high for exactly one cycle. The packet is dropped and the next packet is then served.
- R8: An `ack_in` pulse that arrives while no acknowledgement window is open has no effect.
- R9: `cts` is low while fewer than 100 of the 256 byte slots are free, and high while at least 100 are free.
- R10: Return bytes leave on `out_byte` in arrival order, at most one per cycle. `out_valid` is high only in the cycle after a clock edge at which `rts` was low and `tx_ready` was high.
- R11: Out of reset, `pkt_valid`, `pkt_sop`, `pkt_eop`, `ack_fail` and `out_valid` are low and `cts` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | One pulse per serial bit time |
| idle_chars | input | 8 | Quiet time, in character times, that closes a packet |
| in_valid | input | 1 | Byte from the UART receiver is present |
| in_byte | input | 8 | Received serial byte |
| cts | output | 1 | High when the sender may keep sending |
| pkt_valid | output | 1 | Packet byte present |
| pkt_sop | output | 1 | First byte of a packet |
| pkt_eop | output | 1 | Last byte of a packet |
| pkt_data | output | 8 | Packet byte |
| tx_done | input | 1 | Radio has sent the packet; opens the acknowledgement window |
| ack_in | input | 1 | Acknowledgement pulse from the far end |
| ack_fail | output | 1 | One-cycle pulse when a packet is abandoned |
| rtn_valid | input | 1 | Byte from the radio receive side is present |
| rtn_byte | input | 8 | Radio receive byte |
| rts | input | 1 | High blocks the return stream |
| tx_ready | input | 1 | UART transmitter can take a byte |
| out_valid | output | 1 | Return byte handed to the UART transmitter |
| out_byte | output | 8 | Return byte |

## Verification
A corrupted store pointer or packet length would show up on the first packet streamed afterwards. It appears as wrong bytes, a missing or misplaced `pkt_sop`/`pkt_eop`, or a length other than the number of bytes sent. A stuck attempt counter shows up within four acknowledgement windows: it produces either a fifth transmission or an `ack_fail` pulse at the wrong time. A wrong fill level appears on `cts` one cycle after the byte that crosses the 100-free threshold. On the return side, a broken gate would let a byte out during a cycle that followed an `rts`-high edge.

// File: rtl/pkt_buf_pkg.sv
package pkt_buf_pkg;
  typedef enum logic [1:0] {
    TX_IDLE = 2'd0,
    TX_SEND = 2'd1,
    TX_SENT = 2'd2,
    TX_WAIT = 2'd3
  } tx_state_e;
endpackage

// File: rtl/pkt_sdp_ram.sv
// Simple dual-port store with a registered read port (block RAM friendly).
module pkt_sdp_ram #(
  parameter int W     = 8,
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/pkt_idle_closer.sv
// Tracks the open packet and decides when it closes: size cap or quiet time.
module pkt_idle_closer #(
  parameter int MAX_PKT   = 100,
  parameter int CHAR_BITS = 10,
  parameter int TMO_W     = 8,
  localparam int LEN_W    = $clog2(MAX_PKT + 1),
  localparam int TW       = $clog2(CHAR_BITS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             baud_tick,
  input  logic             byte_acc,
  input  logic [TMO_W-1:0] idle_chars,
  output logic             close,
  output logic [LEN_W-1:0] close_len
);
  logic [LEN_W-1:0] open_cnt;
  logic [TW-1:0]    tick_cnt;
  logic [TMO_W-1:0] char_cnt;

  assign close = (open_cnt != '0) &&
                 ((open_cnt == LEN_W'(MAX_PKT)) || (char_cnt >= idle_chars));
  assign close_len = open_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      open_cnt <= '0;
      tick_cnt <= '0;
      char_cnt <= '0;
    end else if (byte_acc) begin
      // a byte arriving in the closing cycle opens the next packet
      open_cnt <= close ? LEN_W'(1) : open_cnt + LEN_W'(1);
      tick_cnt <= '0;
      char_cnt <= '0;
    end else begin
      if (close) open_cnt <= '0;
      if (baud_tick && open_cnt != '0) begin
        if (tick_cnt == TW'(CHAR_BITS - 1)) begin
          tick_cnt <= '0;
          if (char_cnt != '1) char_cnt <= char_cnt + TMO_W'(1);
        end else begin
          tick_cnt <= tick_cnt + TW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/pkt_tx_seq.sv
// Streams the head packet, waits for the radio and the far-end acknowledgement,
// and repeats the stream on a missed acknowledgement.
module pkt_tx_seq
  import pkt_buf_pkg::*;
#(
  parameter int MAX_PKT  = 100,
  parameter int RETRIES  = 3,
  parameter int ACK_WAIT = 2000,
  localparam int LEN_W   = $clog2(MAX_PKT + 1),
  localparam int WW      = $clog2(ACK_WAIT + 1),
  localparam int RW      = $clog2(RETRIES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             have_pkt,
  input  logic [LEN_W-1:0] head_len,
  input  logic             tx_done,
  input  logic             ack_in,
  output logic             issue,
  output logic [LEN_W-1:0] idx,
  output logic             last,
  output logic             retire,
  output logic             fail
);
  tx_state_e        state;
  logic [LEN_W-1:0] idx_q, len_q;
  logic [RW-1:0]    try_q;
  logic [WW-1:0]    wait_q;
  logic             ack_hit, expired;

  assign issue   = (state == TX_SEND);
  assign idx     = idx_q;
  assign last    = issue && (idx_q == len_q - LEN_W'(1));
  assign ack_hit = (state == TX_WAIT) && ack_in;
  assign expired = (state == TX_WAIT) && !ack_in && (wait_q == WW'(ACK_WAIT - 1));
  assign fail    = expired && (try_q == RW'(RETRIES));
  assign retire  = ack_hit || fail;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= TX_IDLE;
      idx_q  <= '0;
      len_q  <= '0;
      try_q  <= '0;
      wait_q <= '0;
    end else begin
      unique case (state)
        TX_IDLE: if (have_pkt) begin
          len_q <= head_len;
          idx_q <= '0;
          try_q <= '0;
          state <= TX_SEND;
        end
        TX_SEND: if (last) state <= TX_SENT;
                 else idx_q <= idx_q + LEN_W'(1);
        TX_SENT: if (tx_done) begin
          wait_q <= '0;
          state  <= TX_WAIT;
        end
        TX_WAIT: begin
          if (retire) begin
            state <= TX_IDLE;
          end else if (expired) begin
            try_q <= try_q + RW'(1);
            idx_q <= '0;
            state <= TX_SEND;
          end else begin
            wait_q <= wait_q + WW'(1);
          end
        end
        default: state <= TX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pkt_rtn_drain.sv
// Return-direction queue, emptied towards the UART transmitter under rts gating.
module pkt_rtn_drain #(
  parameter int W     = 8,
  parameter int DEPTH = 128,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [W-1:0] in_byte,
  input  logic         rts,
  input  logic         tx_ready,
  output logic         out_valid,
  output logic [W-1:0] out_byte
);
  logic [AW:0] wr_q, rd_q, fill;
  logic        push, pop;

  assign fill = wr_q - rd_q;
  assign push = in_valid && (fill != (AW+1)'(DEPTH));
  assign pop  = (fill != '0) && !rts && tx_ready;

  pkt_sdp_ram #(.W(W), .DEPTH(DEPTH)) i_ram (
    .clk  (clk),
    .we   (push),
    .waddr(wr_q[AW-1:0]),
    .wdata(in_byte),
    .re   (pop),
    .raddr(rd_q[AW-1:0]),
    .rdata(out_byte)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q      <= '0;
      rd_q      <= '0;
      out_valid <= 1'b0;
    end else begin
      if (push) wr_q <= wr_q + (AW+1)'(1);
      if (pop)  rd_q <= rd_q + (AW+1)'(1);
      out_valid <= pop;
    end
  end
endmodule

// File: rtl/pkt_retx_buffer.sv
// Top: byte store, packet length queue, sequencer and return drain.
// BUF_DEPTH and RTN_DEPTH must be powers of two; RETRIES must be at least 1.
module pkt_retx_buffer
  import pkt_buf_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int MAX_PKT   = 100,
  parameter int BUF_DEPTH = 256,
  parameter int RTN_DEPTH = 128,
  parameter int CHAR_BITS = 10,
  parameter int TMO_W     = 8,
  parameter int RETRIES   = 3,
  parameter int ACK_WAIT  = 2000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              baud_tick,
  input  logic [TMO_W-1:0]  idle_chars,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_byte,
  output logic              cts,
  output logic              pkt_valid,
  output logic              pkt_sop,
  output logic              pkt_eop,
  output logic [DATA_W-1:0] pkt_data,
  input  logic              tx_done,
  input  logic              ack_in,
  output logic              ack_fail,
  input  logic              rtn_valid,
  input  logic [DATA_W-1:0] rtn_byte,
  input  logic              rts,
  input  logic              tx_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_byte
);
  localparam int AW    = $clog2(BUF_DEPTH);
  localparam int LEN_W = $clog2(MAX_PKT + 1);

  logic [AW:0]      wr_ptr, base_ptr, used, free, lwr, lrd;
  logic             byte_acc, close, have_pkt;
  logic             issue, last, retire, fail;
  logic [LEN_W-1:0] close_len, head_len, idx;
  logic [AW-1:0]    raddr;
  logic [LEN_W-1:0] len_mem [BUF_DEPTH];

  assign used     = wr_ptr - base_ptr;
  assign free     = (AW+1)'(BUF_DEPTH) - used;
  assign byte_acc = in_valid && (used != (AW+1)'(BUF_DEPTH));
  assign have_pkt = (lwr != lrd);
  assign head_len = len_mem[lrd[AW-1:0]];
  assign raddr    = base_ptr[AW-1:0] + AW'(idx);

  pkt_idle_closer #(.MAX_PKT(MAX_PKT), .CHAR_BITS(CHAR_BITS), .TMO_W(TMO_W)) i_closer (
    .clk       (clk),
    .rst       (rst),
    .baud_tick (baud_tick),
    .byte_acc  (byte_acc),
    .idle_chars(idle_chars),
    .close     (close),
    .close_len (close_len)
  );

  pkt_sdp_ram #(.W(DATA_W), .DEPTH(BUF_DEPTH)) i_store (
    .clk  (clk),
    .we   (byte_acc),
    .waddr(wr_ptr[AW-1:0]),
    .wdata(in_byte),
    .re   (issue),
    .raddr(raddr),
    .rdata(pkt_data)
  );

  pkt_tx_seq #(.MAX_PKT(MAX_PKT), .RETRIES(RETRIES), .ACK_WAIT(ACK_WAIT)) i_seq (
    .clk     (clk),
    .rst     (rst),
    .have_pkt(have_pkt),
    .head_len(head_len),
    .tx_done (tx_done),
    .ack_in  (ack_in),
    .issue   (issue),
    .idx     (idx),
    .last    (last),
    .retire  (retire),
    .fail    (fail)
  );

  pkt_rtn_drain #(.W(DATA_W), .DEPTH(RTN_DEPTH)) i_drain (
    .clk      (clk),
    .rst      (rst),
    .in_valid (rtn_valid),
    .in_byte  (rtn_byte),
    .rts      (rts),
    .tx_ready (tx_ready),
    .out_valid(out_valid),
    .out_byte (out_byte)
  );

  // packet length queue: one entry per closed packet
  always_ff @(posedge clk) begin
    if (close) len_mem[lwr[AW-1:0]] <= close_len;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr    <= '0;
      base_ptr  <= '0;
      lwr       <= '0;
      lrd       <= '0;
      cts       <= 1'b1;
      pkt_valid <= 1'b0;
      pkt_sop   <= 1'b0;
      pkt_eop   <= 1'b0;
      ack_fail  <= 1'b0;
    end else begin
      if (byte_acc) wr_ptr <= wr_ptr + (AW+1)'(1);
      if (close)    lwr    <= lwr + (AW+1)'(1);
      if (retire) begin
        lrd      <= lrd + (AW+1)'(1);
        base_ptr <= base_ptr + (AW+1)'(head_len);
      end
      cts       <= (free >= (AW+1)'(MAX_PKT));
      pkt_valid <= issue;
      pkt_sop   <= issue && (idx == '0);
      pkt_eop   <= last;
      ack_fail  <= fail;
    end
  end
endmodule

// File: rtl/pkt_retx_chk.sv
module pkt_retx_chk #(
  parameter int MAX_PKT   = 100,
  parameter int BUF_DEPTH = 256,
  localparam int AW       = $clog2(BUF_DEPTH),
  localparam int CW       = $clog2(MAX_PKT + 1)
) (
  input logic        clk,
  input logic        rst,
  input logic        cts,
  input logic        pkt_valid,
  input logic        pkt_sop,
  input logic        pkt_eop,
  input logic        ack_fail,
  input logic        out_valid,
  input logic        rts,
  input logic        tx_ready,
  input logic [AW:0] used
);
  logic [CW-1:0] run_cnt;

  always_ff @(posedge clk) begin
    if (rst) run_cnt <= '0;
    else if (pkt_valid) run_cnt <= pkt_eop ? '0 : run_cnt + CW'(1);
  end

  // R3
  pkt_cap_chk: assert property (@(posedge clk) disable iff (rst)
    pkt_valid |-> (run_cnt < CW'(MAX_PKT)));

  // R4
  pkt_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (pkt_valid && !pkt_eop) |=> (pkt_valid && !pkt_sop));

  // R7
  fail_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    ack_fail |=> !ack_fail);

  // R7
  fail_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    ack_fail |-> !pkt_valid);

  // R9
  cts_full_chk: assert property (@(posedge clk) disable iff (rst)
    (used == (AW+1)'(BUF_DEPTH)) |-> !cts);

  // R10
  rts_gate_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(!rts && tx_ready));
endmodule

bind pkt_retx_buffer pkt_retx_chk #(.MAX_PKT(MAX_PKT), .BUF_DEPTH(BUF_DEPTH)) i_chk (
  .clk      (clk),
  .rst      (rst),
  .cts      (cts),
  .pkt_valid(pkt_valid),
  .pkt_sop  (pkt_sop),
  .pkt_eop  (pkt_eop),
  .ack_fail (ack_fail),
  .out_valid(out_valid),
  .rts      (rts),
  .tx_ready (tx_ready),
  .used     (used)
);

// File: tb/test_pkt_retx_buffer.sv
module test_pkt_retx_buffer;
  localparam int ACK_W = 60;

  logic       clk = 1'b0, rst = 1'b1, baud_tick = 1'b0;
  logic [7:0] idle_chars = 8'd3;
  logic       in_valid = 1'b0, tx_done = 1'b0, ack_in = 1'b0;
  logic [7:0] in_byte = '0, rtn_byte = '0;
  logic       rtn_valid = 1'b0, rts = 1'b1, tx_ready = 1'b1;
  logic       cts, pkt_valid, pkt_sop, pkt_eop, ack_fail, out_valid;
  logic [7:0] pkt_data, out_byte;

  always #10 clk = ~clk;

  pkt_retx_buffer #(.ACK_WAIT(ACK_W)) i_pkt_retx_buffer (
    .clk(clk), .rst(rst), .baud_tick(baud_tick), .idle_chars(idle_chars),
    .in_valid(in_valid), .in_byte(in_byte), .cts(cts),
    .pkt_valid(pkt_valid), .pkt_sop(pkt_sop), .pkt_eop(pkt_eop), .pkt_data(pkt_data),
    .tx_done(tx_done), .ack_in(ack_in), .ack_fail(ack_fail),
    .rtn_valid(rtn_valid), .rtn_byte(rtn_byte), .rts(rts), .tx_ready(tx_ready),
    .out_valid(out_valid), .out_byte(out_byte)
  );

  int n_tests = 0, n_fail = 0;
  int eop_cnt = 0, eop_seen = 0, fail_cnt = 0, out_cnt = 0;
  logic [7:0] cap[$];
  logic [7:0] rtn_q[$];
  bit   in_pkt = 0;
  logic rts_seen = 1'b1, rdy_seen = 1'b1;

  function automatic logic [7:0] val(int seed, int i);
    return 8'((seed * 37 + i * 5 + 1) & 255);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // baud tick every 4 clocks
  initial begin
    int div = 0;
    forever begin
      @(negedge clk);
      div++;
      baud_tick = (div % 4 == 0);
    end
  end

  // values of the gating inputs at each active edge
  initial forever begin
    @(posedge clk);
    rts_seen = rts;
    rdy_seen = tx_ready;
  end

  // per-clock reference comparison
  initial forever begin
    @(negedge clk);
    if (!rst) begin
      if (in_pkt && !pkt_valid) check(0, "R4 gap inside packet", 0, 1);
      if (pkt_valid) begin
        check(pkt_sop == (cap.size() == 0), "R4 sop position", int'(pkt_sop), int'(cap.size() == 0));
        cap.push_back(pkt_data);
        in_pkt = !pkt_eop;
        if (pkt_eop) eop_cnt++;
      end
      if (ack_fail) fail_cnt++;
      if (out_valid) begin
        out_cnt++;
        check(!rts_seen && rdy_seen, "R10 gate", int'(rts_seen), 0);
        if (rtn_q.size() == 0) check(0, "R10 unexpected byte", int'(out_byte), -1);
        else begin
          logic [7:0] e;
          e = rtn_q.pop_front();
          check(out_byte == e, "R10 order", int'(out_byte), int'(e));
        end
      end
    end
  end

  task automatic wait_cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bytes(int seed, int first, int n, int gap);
    for (int i = 0; i < n; i++) begin
      in_valid = 1'b1;
      in_byte  = val(seed, first + i);
      @(negedge clk);
      if (gap > 0) begin
        in_valid = 1'b0;
        repeat (gap) @(negedge clk);
      end
    end
    in_valid = 1'b0;
  endtask

  task automatic pulse_done();
    tx_done = 1'b1; @(negedge clk); tx_done = 1'b0;
  endtask

  task automatic pulse_ack();
    ack_in = 1'b1; @(negedge clk); ack_in = 1'b0;
  endtask

  task automatic push_rtn(logic [7:0] v);
    rtn_valid = 1'b1; rtn_byte = v; rtn_q.push_back(v);
    @(negedge clk);
    rtn_valid = 1'b0;
  endtask

  task automatic expect_pkt(int seed, int first, int len, string req);
    int waited = 0;
    int bad = -1;
    while (eop_cnt == eop_seen && waited < 4000) begin
      @(negedge clk);
      waited++;
    end
    check(eop_cnt != eop_seen, {req, " packet arrives"}, eop_cnt - eop_seen, 1);
    if (eop_cnt != eop_seen) begin
      check(cap.size() == len, {req, " length"}, cap.size(), len);
      for (int i = 0; i < cap.size() && i < len; i++)
        if (bad < 0 && cap[i] != val(seed, first + i)) bad = i;
      check(bad < 0, {req, " data"}, (bad >= 0) ? int'(cap[bad]) : 0,
            (bad >= 0) ? int'(val(seed, first + bad)) : 0);
    end
    cap.delete();
    eop_seen = eop_cnt;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
    $finish;
  end

  initial begin
    wait_cycles(5);
    rst = 1'b0;
    @(negedge clk);
    // R11
    check(cts == 1'b1, "R11 cts", int'(cts), 1);
    check(!pkt_valid && !pkt_sop && !pkt_eop, "R11 pkt idle", int'(pkt_valid), 0);
    check(ack_fail == 1'b0, "R11 ack_fail", int'(ack_fail), 0);
    check(out_valid == 1'b0, "R11 out_valid", int'(out_valid), 0);

    // R1: bytes 100 cycles apart (2.5 chars) stay together; quiet 3 chars closes
    idle_chars = 8'd3;
    send_bytes(1, 0, 5, 100);
    check(eop_cnt == eop_seen && cap.size() == 0, "R1 early close", cap.size(), 0);
    expect_pkt(1, 0, 5, "R1");
    pulse_done();
    wait_cycles(5);
    pulse_ack();
    wait_cycles(ACK_W + 20);
    check(eop_cnt == eop_seen, "R5 no resend after ack", eop_cnt - eop_seen, 0);
    check(fail_cnt == 0, "R5 no failure", fail_cnt, 0);

    // R2: zero timeout, back-to-back bytes each form a packet
    idle_chars = 8'd0;
    send_bytes(2, 0, 3, 0);
    for (int k = 0; k < 3; k++) begin
      expect_pkt(2, k, 1, "R2");
      pulse_done();
      pulse_ack();
    end
    wait_cycles(20);

    // R3 and R9: size cap and flow control
    idle_chars = 8'd255;
    send_bytes(3, 0, 100, 0);
    expect_pkt(3, 0, 100, "R3");
    send_bytes(3, 100, 56, 0);
    wait_cycles(3);
    check(cts == 1'b1, "R9 cts at 100 free", int'(cts), 1);
    send_bytes(3, 156, 1, 0);
    wait_cycles(3);
    check(cts == 1'b0, "R9 cts at 99 free", int'(cts), 0);
    pulse_done();
    pulse_ack();
    wait_cycles(3);
    check(cts == 1'b1, "R9 cts after release", int'(cts), 1);
    idle_chars = 8'd1;
    expect_pkt(3, 100, 57, "R3 next packet");
    pulse_done();
    pulse_ack();
    wait_cycles(10);

    // R8, R6, R7: stray ack ignored, four transmissions, then failure
    pulse_ack();
    send_bytes(5, 0, 4, 0);
    expect_pkt(5, 0, 4, "R4");
    pulse_ack();
    pulse_done();
    for (int a = 2; a <= 4; a++) begin
      expect_pkt(5, 0, 4, "R6 R8 resend");
      pulse_done();
    end
    wait_cycles(ACK_W + 20);
    check(fail_cnt == 1, "R7 ack_fail pulse", fail_cnt, 1);
    check(eop_cnt == eop_seen, "R6 no fifth send", eop_cnt - eop_seen, 0);
    send_bytes(6, 0, 2, 0);
    expect_pkt(6, 0, 2, "R7 next packet");
    pulse_done();
    pulse_ack();
    wait_cycles(10);

    // R5 with R6: ack on the second transmission stops resends
    send_bytes(7, 0, 3, 0);
    expect_pkt(7, 0, 3, "R5");
    pulse_done();
    expect_pkt(7, 0, 3, "R6 second send");
    pulse_done();
    wait_cycles(5);
    pulse_ack();
    wait_cycles(ACK_W + 20);
    check(eop_cnt == eop_seen, "R5 resend stopped", eop_cnt - eop_seen, 0);
    check(fail_cnt == 1, "R5 no new failure", fail_cnt, 1);

    // R10: return drain gated by rts and tx_ready
    rts = 1'b1;
    tx_ready = 1'b1;
    for (int b = 0; b < 4; b++) push_rtn(8'(8'h30 + b));
    wait_cycles(20);
    check(out_cnt == 0, "R10 held by rts", out_cnt, 0);
    rts = 1'b0;
    wait_cycles(20);
    check(out_cnt == 4, "R10 drained", out_cnt, 4);
    tx_ready = 1'b0;
    push_rtn(8'hA5);
    push_rtn(8'h5A);
    wait_cycles(10);
    check(out_cnt == 4, "R10 held by tx_ready", out_cnt, 4);
    tx_ready = 1'b1;
    wait_cycles(10);
    check(out_cnt == 6 && rtn_q.size() == 0, "R10 all out", out_cnt, 6);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule